// File: doc/BRIEF.md
# Peripheral Slot Bus Slave Engine

This block is the card-side timing engine for an 8-bit retro peripheral slot bus. The host marks each bus cycle by pulling any one of three active-low slot selects low. The block merges the three selects into one enable, passes the enable, the address, the direction and the data lines through a two-stage synchroniser, and tracks the edges of the synchronised enable. It does not decode what an address means. It does not generate any system clock.

On every falling enable edge the block presents one captured-cycle word to the card logic: the 12-bit address with the read/write flag on top. For a host write, it waits a fixed number of clocks so the host can settle the data bus, samples the byte, and presents it with a one-cycle valid. For a host read, the card logic may answer with a byte and a valid pulse. The block then drives that byte on the data bus, with all eight output enables asserted together, until the enable rises. At that point it releases all eight drivers at once.

Top module: `slot_bus_slave`

## Requirements
- R1: The internal enable is the AND of `dev_sel_ni`, `io_sel_ni` and `io_strb_ni`, so a low level on any one or more of them opens a bus cycle.
- R2: `cyc_valid_o` pulses for one cycle on the third rising clock after the enable falls, with `cyc_word_o` = {rw, addr} (bit 12 = `rw_i`, bits 11:0 = `addr_i`).
- R3: One enable low period yields exactly one capture, however long it lasts. An enable that is already low when reset is released, and was never seen high, yields no capture.
- R4: In a write cycle (`rw_i` = 0), `wr_valid_o` pulses for one cycle exactly 32 clocks after `cyc_valid_o`, with `wr_data_o` equal to the byte held on `data_i`.
- R5: A read cycle (`rw_i` = 1) produces no `wr_valid_o` pulse.
- R6: A `rd_valid_i` pulse during an open read cycle makes `data_o` equal `rd_data_i` and `data_oe_o` = 8'hFF from the next clock on. Both hold steady while the cycle lasts.
- R7: The driven bus stays driven until the enable rises. `data_oe_o` returns to 8'h00 on the third clock after the rise, with all eight bits changing together.
- R8: The following responses are discarded and leave `data_oe_o` at zero or unchanged:
  - a response that arrives after the enable has risen;
  - a response during a write cycle;
  - a second response in the same read cycle.
  When no response arrives, the bus stays tri-stated.
- R9: While `rst_ni` is low, all pending state is cleared, `cyc_valid_o` and `wr_valid_o` are 0, and `data_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Design clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dev_sel_ni | input | 1 | Device select, active low |
| io_sel_ni | input | 1 | I/O select, active low |
| io_strb_ni | input | 1 | I/O strobe, active low |
| addr_i | input | 12 | Bus address lines |
| rw_i | input | 1 | Bus direction, 1 = host read |
| data_i | input | 8 | Data bus as seen at the pins |
| data_o | output | 8 | Byte driven onto the data bus |
| data_oe_o | output | 8 | Per-line output enable for the data bus |
| cyc_valid_o | output | 1 | One-cycle strobe for a captured cycle |
| cyc_word_o | output | 13 | Captured {rw, addr} |
| wr_valid_o | output | 1 | One-cycle strobe for sampled write data |
| wr_data_o | output | 8 | Sampled write byte |
| rd_valid_i | input | 1 | Read response strobe from card logic |
| rd_data_i | input | 8 | Read response byte |

## Verification
The hardest window to reach from the ports is the narrow one around the end of a read cycle. This covers two cases. In the first, the enable has already risen at the pins, but the rise has not yet passed through the synchroniser, so the bus must stay driven. In the second, a response arrives just after the release. The stimulus places the enable rise on a falling clock edge and then counts rising edges exactly. It checks that the drivers are still on after two edges and off after the third, and then pulses a late response to confirm that the drivers stay off. Sweeps over every combination of asserted selects and several address and data patterns cover capture and write sampling.

// File: rtl/slot_bus_pkg.sv
package slot_bus_pkg;
  parameter int unsigned ADDR_W = 12;
  parameter int unsigned DATA_W = 8;
  parameter int unsigned CYC_W  = ADDR_W + 1;
endpackage

// File: rtl/slot_sync.sv
module slot_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/slot_cycle_cap.sv
module slot_cycle_cap import slot_bus_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_s_i,
  input  logic              rw_s_i,
  input  logic [ADDR_W-1:0] addr_s_i,
  output logic              en_fall_o,
  output logic              en_rise_o,
  output logic              cyc_valid_o,
  output logic [CYC_W-1:0]  cyc_word_o
);
  // en_q resets low: a fall needs a high level observed after reset
  logic en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_s_i;
  end

  assign en_fall_o = en_q & ~en_s_i;
  assign en_rise_o = ~en_q & en_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_valid_o <= 1'b0;
      cyc_word_o  <= '0;
    end else begin
      cyc_valid_o <= en_fall_o;
      if (en_fall_o) cyc_word_o <= {rw_s_i, addr_s_i};
    end
  end

  AST_SINGLE_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_valid_o |=> !cyc_valid_o); // R3
endmodule

// File: rtl/slot_wr_sampler.sv
module slot_wr_sampler import slot_bus_pkg::*; #(
  parameter int unsigned WR_DELAY = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_s_i,
  output logic              busy_o,
  output logic              wr_valid_o,
  output logic [DATA_W-1:0] wr_data_o
);
  localparam int unsigned CNT_W = $clog2(WR_DELAY + 2);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o     <= 1'b0;
      cnt_q      <= '0;
      wr_valid_o <= 1'b0;
      wr_data_o  <= '0;
    end else begin
      wr_valid_o <= 1'b0;
      if (start_i) begin
        busy_o <= 1'b1;
        cnt_q  <= CNT_W'(WR_DELAY);
      end else if (busy_o) begin
        if (cnt_q == '0) begin
          busy_o     <= 1'b0;
          wr_valid_o <= 1'b1;
          wr_data_o  <= data_s_i;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  AST_WR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |=> !wr_valid_o); // R4
endmodule

// File: rtl/slot_rd_driver.sv
module slot_rd_driver import slot_bus_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              open_i,
  input  logic              close_i,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] data_oe_o
);
  logic open_q, drive_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q  <= 1'b0;
      drive_q <= 1'b0;
      data_o  <= '0;
    end else if (close_i) begin
      open_q  <= 1'b0;
      drive_q <= 1'b0;
      data_o  <= '0;
    end else if (open_i) begin
      open_q  <= 1'b1;
      drive_q <= 1'b0;
    end else if (open_q && !drive_q && rd_valid_i) begin
      drive_q <= 1'b1;
      data_o  <= rd_data_i;
    end
  end

  // one enable bit drives all lanes so they switch in the same cycle
  assign data_oe_o = {DATA_W{drive_q}};

  AST_RELEASE_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_i |=> data_oe_o == '0); // R7
  AST_DRIVE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_q && !close_i && !open_i) |=> ($stable(data_o) && (&data_oe_o))); // R6
  AST_DRIVE_NEEDS_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drive_q) |-> $past(rd_valid_i)); // R6
endmodule

// File: rtl/slot_bus_slave.sv
module slot_bus_slave import slot_bus_pkg::*; #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned WR_DELAY    = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dev_sel_ni,
  input  logic              io_sel_ni,
  input  logic              io_strb_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rw_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] data_oe_o,
  output logic              cyc_valid_o,
  output logic [CYC_W-1:0]  cyc_word_o,
  output logic              wr_valid_o,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i
);
  localparam int unsigned SYNC_W = 2 + ADDR_W + DATA_W;

  logic              en_raw, en_s, rw_s, en_fall, en_rise, wr_busy;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] data_s;

  assign en_raw = dev_sel_ni & io_sel_ni & io_strb_ni;

  slot_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({en_raw, rw_i, addr_i, data_i}),
    .q_o    ({en_s, rw_s, addr_s, data_s})
  );

  slot_cycle_cap u_cap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_s_i      (en_s),
    .rw_s_i      (rw_s),
    .addr_s_i    (addr_s),
    .en_fall_o   (en_fall),
    .en_rise_o   (en_rise),
    .cyc_valid_o (cyc_valid_o),
    .cyc_word_o  (cyc_word_o)
  );

  slot_wr_sampler #(.WR_DELAY(WR_DELAY)) u_wr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (en_fall & ~rw_s),
    .data_s_i   (data_s),
    .busy_o     (wr_busy),
    .wr_valid_o (wr_valid_o),
    .wr_data_o  (wr_data_o)
  );

  slot_rd_driver u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .open_i     (en_fall & rw_s),
    .close_i    (en_rise),
    .rd_valid_i (rd_valid_i),
    .rd_data_i  (rd_data_i),
    .data_o     (data_o),
    .data_oe_o  (data_oe_o)
  );

  AST_NO_WR_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_valid_o && cyc_word_o[CYC_W-1]) |-> !wr_busy); // R5
  AST_NO_DRIVE_IN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_busy |-> data_oe_o == '0); // R8
endmodule

// File: tb/slot_bus_slave_tb.sv
`timescale 1ns/1ps
module slot_bus_slave_tb;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        dev_sel_ni = 1'b1, io_sel_ni = 1'b1, io_strb_ni = 1'b1;
  logic [11:0] addr_i = '0;
  logic        rw_i = 1'b1;
  logic [7:0]  data_i = '0;
  logic [7:0]  data_o, data_oe_o, wr_data_o;
  logic        cyc_valid_o, wr_valid_o;
  logic [12:0] cyc_word_o;
  logic        rd_valid_i = 1'b0;
  logic [7:0]  rd_data_i = '0;

  int checks = 0, fails = 0, cyc_cnt = 0, wr_cnt = 0;

  always #4 clk_i = ~clk_i;

  slot_bus_slave u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .dev_sel_ni(dev_sel_ni), .io_sel_ni(io_sel_ni), .io_strb_ni(io_strb_ni),
    .addr_i(addr_i), .rw_i(rw_i), .data_i(data_i),
    .data_o(data_o), .data_oe_o(data_oe_o),
    .cyc_valid_o(cyc_valid_o), .cyc_word_o(cyc_word_o),
    .wr_valid_o(wr_valid_o), .wr_data_o(wr_data_o),
    .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i)
  );

  always @(posedge clk_i) if (rst_ni) begin
    if (cyc_valid_o) cyc_cnt <= cyc_cnt + 1;
    if (wr_valid_o)  wr_cnt  <= wr_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_sel(input logic [2:0] sel);
    {io_strb_ni, io_sel_ni, dev_sel_ni} = ~sel;
  endtask

  task automatic bus_write(input logic [2:0] sel, input logic [11:0] a, input logic [7:0] d);
    @(negedge clk_i);
    set_sel(sel); rw_i = 1'b0; addr_i = a; data_i = d;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check(cyc_valid_o && cyc_word_o == {1'b0, a}, "R1 R2 write capture", cyc_word_o, {1'b0, a});
    rd_valid_i = 1'b1; rd_data_i = 8'h5A;
    @(posedge clk_i); @(negedge clk_i);
    rd_valid_i = 1'b0;
    check(data_oe_o == 8'h00, "R8 response in write cycle", data_oe_o, 0);
    repeat (30) @(posedge clk_i);
    @(negedge clk_i);
    check(!wr_valid_o, "R4 not before delay", wr_valid_o, 0);
    @(posedge clk_i); @(negedge clk_i);
    check(wr_valid_o && wr_data_o == d, "R4 write sample", wr_data_o, d);
    set_sel(3'b000); rw_i = 1'b1;
    repeat (4) @(posedge clk_i);
  endtask

  task automatic bus_read(input logic [2:0] sel, input logic [11:0] a, input bit respond,
                          input logic [7:0] d, input bit late);
    int w0;
    w0 = wr_cnt;
    @(negedge clk_i);
    set_sel(sel); rw_i = 1'b1; addr_i = a; data_i = ~d;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check(cyc_valid_o && cyc_word_o == {1'b1, a}, "R2 read capture", cyc_word_o, {1'b1, a});
    if (respond) begin
      rd_valid_i = 1'b1; rd_data_i = d;
      @(posedge clk_i); @(negedge clk_i);
      rd_valid_i = 1'b0;
      check(data_oe_o == 8'hFF && data_o == d, "R6 drive response", data_o, d);
      rd_valid_i = 1'b1; rd_data_i = ~d;
      @(posedge clk_i); @(negedge clk_i);
      rd_valid_i = 1'b0;
      repeat (3) @(posedge clk_i);
      @(negedge clk_i);
      check(data_oe_o == 8'hFF && data_o == d, "R6 R8 hold first byte", data_o, d);
    end else begin
      repeat (5) @(posedge clk_i);
      @(negedge clk_i);
      check(data_oe_o == 8'h00, "R8 no response stays released", data_oe_o, 0);
    end
    set_sel(3'b000);
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    if (respond) check(data_oe_o == 8'hFF, "R7 driven until rise seen", data_oe_o, 8'hFF);
    @(posedge clk_i); @(negedge clk_i);
    check(data_oe_o == 8'h00 && data_o == 8'h00, "R7 release", data_oe_o, 0);
    if (late) begin
      rd_valid_i = 1'b1; rd_data_i = d;
      @(posedge clk_i); @(negedge clk_i);
      rd_valid_i = 1'b0;
      repeat (2) @(posedge clk_i);
      @(negedge clk_i);
      check(data_oe_o == 8'h00, "R8 late response", data_oe_o, 0);
    end
    repeat (36) @(posedge clk_i);
    @(negedge clk_i);
    check(wr_cnt == w0, "R5 no write sample on read", wr_cnt - w0, 0);
  endtask

  initial begin
    #150000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    dev_sel_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check(data_oe_o == 0 && !cyc_valid_o && !wr_valid_o, "R9 reset state", data_oe_o, 0);
    rst_ni = 1'b1;
    repeat (10) @(posedge clk_i);
    @(negedge clk_i);
    check(cyc_cnt == 0, "R3 no capture without prior high", cyc_cnt, 0);
    dev_sel_ni = 1'b1;
    repeat (5) @(posedge clk_i);

    for (int s = 1; s < 8; s++)
      bus_write(3'(s), 12'(s * 12'h249 + 12'h0F0), 8'(s * 37 + 1));
    bus_write(3'b001, 12'hFFF, 8'h00);
    bus_write(3'b100, 12'h000, 8'hFF);

    for (int k = 0; k < 8; k++)
      bus_read(3'(k % 7 + 1), 12'(k * 12'h511), 1'b1, 8'(8'hA5 ^ (k * 29)), k[0]);
    bus_read(3'b010, 12'h0FB, 1'b0, 8'h3C, 1'b1);

    begin
      int c0;
      c0 = cyc_cnt;
      @(negedge clk_i);
      set_sel(3'b011); rw_i = 1'b1;
      repeat (60) @(posedge clk_i);
      @(negedge clk_i);
      set_sel(3'b000);
      repeat (5) @(posedge clk_i);
      @(negedge clk_i);
      check(cyc_cnt == c0 + 1, "R3 one capture per low period", cyc_cnt - c0, 1);
    end

    begin
      int c0;
      c0 = cyc_cnt;
      bus_read(3'b001, 12'h123, 1'b1, 8'h77, 1'b0);
      @(negedge clk_i);
      set_sel(3'b101); rw_i = 1'b1; addr_i = 12'h456;
      repeat (8) @(posedge clk_i);
      rst_ni = 1'b0;
      @(negedge clk_i);
      check(data_oe_o == 0 && !cyc_valid_o && !wr_valid_o, "R9 reset mid cycle", data_oe_o, 0);
      set_sel(3'b000);
      rst_ni = 1'b1;
      repeat (5) @(posedge clk_i);
      @(negedge clk_i);
      check(cyc_cnt == c0 + 2, "R1 cycle counts", cyc_cnt - c0, 2);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule